// File: doc/BRIEF.md
# Subtractive Decode and Master-Abort Monitor

This block watches every address phase on a parallel shared bus and measures how many clock cycles pass before any target answers with DEVSEL#. It serves two roles with one counter. As a bridge toward a legacy bus, it claims unanswered accesses that fall inside the legacy windows: the low 64 KiB of I/O space and the low 16 MiB of memory space. As an initiator, it declares a master abort when nobody answers in time. It then asks its own FRAME# driver to let go and returns all-ones data for a read.

The address and command are captured on the first cycle of the transaction. Each later cycle advances the count until DEVSEL# is seen low. A subtractive claim is allowed on cycle 5, or on cycle 3 when the system reports that every positive decoder answers with medium or fast timing. A master abort fires on cycle 6. Each transaction can have at most one of these two outcomes. The outcome is cleared once the bus goes idle. The master-abort status bit stays set until software clears it with a one-cycle pulse.

Top module: `subdec_abort_unit`

## Requirements
- R1: With `fast_decode` low, an in-range access that has not seen DEVSEL# low raises `sub_claim` after the 5th rising edge at which `frame_n` is sampled low, and not before.
- R2: With `fast_decode` high, the same claim is raised after the 3rd such edge instead.
- R3: An I/O command (`cmd` 0010 or 0011) is in range only when address bits 31..16 are zero. A memory command (`cmd` 0110, 0111, 1100, 1110 or 1111) is in range only when address bits 31..24 are zero. An out-of-range access is never claimed.
- R4: Any other command value (for example 1010) is never claimed, whatever its address.
- R5: If DEVSEL# is sampled low on or before the decision cycle, that decision is suppressed. Neither a claim nor an abort is raised.
- R6: If no DEVSEL# is seen and there is no claim, `frame_release` and `abort_sticky` rise after the 6th edge.
- R7: While an abort is active on a read command (`cmd` 0010, 0110, 1010, 1100 or 1110), `read_data` is 0xFFFFFFFF. In all other cases `read_data` equals `bus_rdata`.
- R8: `abort_sticky` stays high until a high `abort_clr` is sampled. A new abort in that same cycle wins over the clear.
- R9: A transaction that has been claimed never aborts. The two outcomes are never active together.
- R10: An edge at which `frame_n` and `devsel_n` are both high ends the transaction. It clears `sub_claim` and `frame_release`, but it does not clear `abort_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Bus FRAME#, active low |
| devsel_n | input | 1 | Bus DEVSEL#, active low |
| addr | input | 32 | Address, captured on the first cycle |
| cmd | input | 4 | Bus command, captured on the first cycle |
| fast_decode | input | 1 | All positive decoders are medium speed or faster |
| bus_rdata | input | 32 | Read data from the bus |
| abort_clr | input | 1 | Write-one-to-clear pulse for the abort status |
| sub_claim | output | 1 | Subtractive claim, drives the bridge's DEVSEL# |
| frame_release | output | 1 | Request to deassert the initiator's FRAME# |
| abort_sticky | output | 1 | Sticky master-abort status |
| read_data | output | 32 | Read data, with all ones substituted on an abort |

## Verification
The bench looks for claims raised one cycle early or late at both the cycle-5 and cycle-3 windows. An off-by-one counter would show up there. It probes the range limits with addresses one above and one below the legacy windows, and uses a command outside both spaces that would be wrongly claimed if the decoder fell back to a default. A DEVSEL# arriving just before the decision cycle must suppress both outcomes; a design that fails to freeze the count would claim or abort anyway. The bench also checks that the sticky bit survives the return to idle, and that a write abort does not corrupt the read data.

// File: rtl/sda_pkg.sv
package sda_pkg;

  typedef enum logic [1:0] {
    SPACE_NONE = 2'd0,
    SPACE_IO   = 2'd1,
    SPACE_MEM  = 2'd2
  } space_e;

  function automatic space_e space_of(input logic [3:0] c);
    case (c)
      4'b0010, 4'b0011:                           space_of = SPACE_IO;
      4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: space_of = SPACE_MEM;
      default:                                    space_of = SPACE_NONE;
    endcase
  endfunction

  function automatic logic is_read_cmd(input logic [3:0] c);
    case (c)
      4'b0010, 4'b0110, 4'b1010, 4'b1100, 4'b1110: is_read_cmd = 1'b1;
      default:                                     is_read_cmd = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sda_range_check.sv
module sda_range_check
  import sda_pkg::*;
#(
  parameter int AW       = 32,
  parameter int IO_BITS  = 16,
  parameter int MEM_BITS = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    cmd,
  output logic          hit,
  output logic          hit_q,
  output logic          rd_q
);

  logic   io_ok, mem_ok, hit_now, hit_d, rd_d;
  space_e sp;

  always_comb begin
    sp      = space_of(cmd);
    io_ok   = ((addr >> IO_BITS) == '0);
    mem_ok  = ((addr >> MEM_BITS) == '0);
    case (sp)
      SPACE_IO:  hit_now = io_ok;
      SPACE_MEM: hit_now = mem_ok;
      default:   hit_now = 1'b0;
    endcase
    hit_d = start ? hit_now : hit_q;
    rd_d  = start ? is_read_cmd(cmd) : rd_q;
    hit   = hit_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      hit_q <= hit_d;
      rd_q  <= rd_d;
    end
  end

endmodule

// File: rtl/sda_phase_counter.sv
module sda_phase_counter #(
  parameter int MAX_CYC = 6,
  localparam int CW     = $clog2(MAX_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic          devsel_n,
  output logic          start,
  output logic          idle,
  output logic          open,
  output logic [CW-1:0] tick
);

  logic          busy_q, busy_d;
  logic          seen_q, seen_d;
  logic [CW-1:0] cnt_q,  cnt_d;

  always_comb begin
    start  = !busy_q && !frame_n;
    idle   = busy_q && frame_n && devsel_n;
    open   = !frame_n && devsel_n && (start || (busy_q && !seen_q));
    busy_d = busy_q;
    seen_d = seen_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      seen_d = !devsel_n;
      cnt_d  = CW'(1);
    end else if (idle) begin
      busy_d = 1'b0;
      seen_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      seen_d = seen_q || !devsel_n;
      if (open && cnt_q != CW'(MAX_CYC)) cnt_d = cnt_q + CW'(1);
    end
    tick = cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      seen_q <= seen_d;
      cnt_q  <= cnt_d;
    end
  end

  p_count_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && seen_q && !frame_n) |=> $stable(cnt_q));

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(MAX_CYC));

endmodule

// File: rtl/sda_outcome.sv
module sda_outcome #(
  parameter int CLAIM_SLOW = 5,
  parameter int CLAIM_FAST = 3,
  parameter int ABORT_CYC  = 6,
  localparam int CW        = $clog2(ABORT_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle,
  input  logic          open,
  input  logic [CW-1:0] tick,
  input  logic          hit,
  input  logic          hit_q,
  input  logic          fast_decode,
  input  logic          abort_clr,
  output logic          claim_q,
  output logic          abort_q,
  output logic          sticky_q
);

  logic          claim_d, abort_d, sticky_d;
  logic          claim_now, abort_now;
  logic [CW-1:0] claim_cyc;

  always_comb begin
    claim_cyc = fast_decode ? CW'(CLAIM_FAST) : CW'(CLAIM_SLOW);
    claim_now = open && hit && !claim_q && !abort_q && (tick == claim_cyc);
    abort_now = open && !claim_q && !abort_q && (tick == CW'(ABORT_CYC));
    claim_d   = idle ? 1'b0 : (claim_q || claim_now);
    abort_d   = idle ? 1'b0 : (abort_q || abort_now);
    sticky_d  = sticky_q;
    if (abort_clr) sticky_d = 1'b0;
    if (abort_now) sticky_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claim_q  <= 1'b0;
      abort_q  <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      claim_q  <= claim_d;
      abort_q  <= abort_d;
      sticky_q <= sticky_d;
    end
  end

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(claim_q && abort_q));

  p_claim_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    claim_q |-> hit_q);

  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q && !abort_clr) |=> sticky_q);

  p_idle_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (!claim_q && !abort_q));

  p_abort_sets_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_q) |-> sticky_q);

endmodule

// File: rtl/subdec_abort_unit.sv
module subdec_abort_unit #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int IO_BITS    = 16,
  parameter int MEM_BITS   = 24,
  parameter int CLAIM_SLOW = 5,
  parameter int CLAIM_FAST = 3,
  parameter int ABORT_CYC  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_n,
  input  logic          devsel_n,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    cmd,
  input  logic          fast_decode,
  input  logic [DW-1:0] bus_rdata,
  input  logic          abort_clr,
  output logic          sub_claim,
  output logic          frame_release,
  output logic          abort_sticky,
  output logic [DW-1:0] read_data
);

  localparam int CW = $clog2(ABORT_CYC + 1);

  logic          rst_s1, rst_s2;
  logic          start, idle, open, hit, hit_q, rd_q;
  logic          claim_q, abort_q, sticky_q;
  logic [CW-1:0] tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  sda_phase_counter #(.MAX_CYC(ABORT_CYC)) u_cnt (
    .clk(clk), .rst_n(rst_s2), .frame_n(frame_n), .devsel_n(devsel_n),
    .start(start), .idle(idle), .open(open), .tick(tick)
  );

  sda_range_check #(.AW(AW), .IO_BITS(IO_BITS), .MEM_BITS(MEM_BITS)) u_rng (
    .clk(clk), .rst_n(rst_s2), .start(start), .addr(addr), .cmd(cmd),
    .hit(hit), .hit_q(hit_q), .rd_q(rd_q)
  );

  sda_outcome #(.CLAIM_SLOW(CLAIM_SLOW), .CLAIM_FAST(CLAIM_FAST),
                .ABORT_CYC(ABORT_CYC)) u_out (
    .clk(clk), .rst_n(rst_s2), .idle(idle), .open(open), .tick(tick),
    .hit(hit), .hit_q(hit_q), .fast_decode(fast_decode),
    .abort_clr(abort_clr), .claim_q(claim_q), .abort_q(abort_q),
    .sticky_q(sticky_q)
  );

  always_comb begin
    sub_claim     = claim_q;
    frame_release = abort_q;
    abort_sticky  = sticky_q;
    read_data     = (abort_q && rd_q) ? {DW{1'b1}} : bus_rdata;
  end

  p_release_needs_silence_r5: assert property (@(posedge clk) disable iff (!rst_s2)
    $rose(frame_release) |-> $past(devsel_n));

endmodule

// File: tb/subdec_abort_unit_test.sv
module subdec_abort_unit_test;

  logic        clk = 1'b0;
  logic        rst_n, frame_n, devsel_n, fast_decode, abort_clr;
  logic [31:0] addr, bus_rdata, read_data;
  logic [3:0]  cmd;
  logic        sub_claim, frame_release, abort_sticky;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  subdec_abort_unit uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .devsel_n(devsel_n),
    .addr(addr), .cmd(cmd), .fast_decode(fast_decode), .bus_rdata(bus_rdata),
    .abort_clr(abort_clr), .sub_claim(sub_claim), .frame_release(frame_release),
    .abort_sticky(abort_sticky), .read_data(read_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic begin_txn(input logic [3:0] c, input logic [31:0] a, input logic f);
    @(negedge clk);
    cmd = c; addr = a; fast_decode = f; frame_n = 1'b0; devsel_n = 1'b1;
  endtask

  task automatic end_txn();
    frame_n = 1'b1; devsel_n = 1'b1;
    steps(1);
  endtask

  task automatic clear_status();
    abort_clr = 1'b1;
    steps(1);
    abort_clr = 1'b0;
    steps(1);
  endtask

  task automatic t_reset();
    chk("R10 reset claim", {31'd0, sub_claim}, 32'd0);
    chk("R10 reset release", {31'd0, frame_release}, 32'd0);
    chk("R8 reset sticky", {31'd0, abort_sticky}, 32'd0);
    chk("R7 reset data", read_data, bus_rdata);
  endtask

  task automatic t_mem_slow_claim();
    begin_txn(4'b0110, 32'h00FF_FFFC, 1'b0);
    steps(4);
    chk("R1 no claim at cycle 4", {31'd0, sub_claim}, 32'd0);
    steps(1);
    chk("R1 claim at cycle 5", {31'd0, sub_claim}, 32'd1);
    devsel_n = 1'b0;
    steps(1);
    chk("R9 claimed never aborts", {31'd0, frame_release}, 32'd0);
    chk("R9 claimed data passthrough", read_data, bus_rdata);
    end_txn();
    chk("R10 idle clears claim", {31'd0, sub_claim}, 32'd0);
  endtask

  task automatic t_io_fast_claim();
    begin_txn(4'b0011, 32'h0000_FFFF, 1'b1);
    steps(2);
    chk("R2 no claim at cycle 2", {31'd0, sub_claim}, 32'd0);
    steps(1);
    chk("R2 claim at cycle 3", {31'd0, sub_claim}, 32'd1);
    devsel_n = 1'b0;
    steps(4);
    chk("R9 fast claim no abort", {31'd0, abort_sticky}, 32'd0);
    end_txn();
  endtask

  task automatic t_io_range_abort();
    begin_txn(4'b0010, 32'h0001_0000, 1'b0);
    steps(5);
    chk("R3 io out of range not claimed", {31'd0, sub_claim}, 32'd0);
    chk("R6 no release at cycle 5", {31'd0, frame_release}, 32'd0);
    steps(1);
    chk("R6 release at cycle 6", {31'd0, frame_release}, 32'd1);
    chk("R6 status set", {31'd0, abort_sticky}, 32'd1);
    chk("R7 read abort all ones", read_data, 32'hFFFF_FFFF);
    end_txn();
    chk("R10 idle clears release", {31'd0, frame_release}, 32'd0);
    chk("R10 data passthrough after idle", read_data, bus_rdata);
    chk("R8 sticky survives idle", {31'd0, abort_sticky}, 32'd1);
    steps(3);
    chk("R8 sticky holds", {31'd0, abort_sticky}, 32'd1);
    clear_status();
    chk("R8 clear pulse", {31'd0, abort_sticky}, 32'd0);
  endtask

  task automatic t_mem_range_edge();
    begin_txn(4'b0111, 32'h0100_0000, 1'b1);
    steps(5);
    chk("R3 mem out of range not claimed", {31'd0, sub_claim}, 32'd0);
    steps(1);
    chk("R6 write abort release", {31'd0, frame_release}, 32'd1);
    chk("R7 write abort passthrough", read_data, bus_rdata);
    end_txn();
    clear_status();
  endtask

  task automatic t_other_cmd();
    begin_txn(4'b1010, 32'h0000_0000, 1'b0);
    steps(5);
    chk("R4 other command not claimed", {31'd0, sub_claim}, 32'd0);
    steps(1);
    chk("R4 other command aborts", {31'd0, frame_release}, 32'd1);
    chk("R7 config read all ones", read_data, 32'hFFFF_FFFF);
    end_txn();
    clear_status();
  endtask

  task automatic t_devsel_early();
    begin_txn(4'b0111, 32'h0000_0010, 1'b0);
    steps(3);
    devsel_n = 1'b0;
    steps(2);
    chk("R5 devsel suppresses claim", {31'd0, sub_claim}, 32'd0);
    steps(2);
    chk("R5 devsel suppresses abort", {31'd0, frame_release}, 32'd0);
    chk("R5 status untouched", {31'd0, abort_sticky}, 32'd0);
    end_txn();
  endtask

  task automatic t_set_wins();
    begin_txn(4'b0110, 32'h0200_0000, 1'b0);
    steps(5);
    abort_clr = 1'b1;
    steps(1);
    abort_clr = 1'b0;
    chk("R8 set wins over clear", {31'd0, abort_sticky}, 32'd1);
    end_txn();
    clear_status();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_n = 1'b1; devsel_n = 1'b1; fast_decode = 1'b0;
    abort_clr = 1'b0; addr = '0; cmd = '0; bus_rdata = 32'h1234_5678;
    steps(3);
    t_reset();
    rst_n = 1'b1;
    steps(4);
    t_mem_slow_claim();
    t_io_fast_claim();
    t_io_range_abort();
    t_mem_range_edge();
    t_other_cmd();
    t_devsel_early();
    t_set_wins();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule